// File: doc/BRIEF.md
# Loadable Binary Counter with Prioritised Controls

This block is a 4-bit synchronous up-counter that can also take a parallel value. Three controls act on it: an asynchronous clear that is always active-low, a load enable and an increment enable. A parameter sets whether load and increment assert on a low level or on a high level. When several controls are asserted together, they act in a fixed order: clear first, then load, then increment.

An elaboration option adds divide-by-12 operation. One AND-gate decode recognises the terminal count 11 (binary 1011). That decode feeds back into the load path with zero as the data, so the count runs 0 through 11 and starts again. While the count sits at 11, a strobe output is high for that clock. The block is meant to drop into a larger design as a small timer or sequence counter.

Top module: `lcnt_top`

## Requirements
- R1: While `clr_n` is low, `cnt_o` is 0 at once, with no clock edge needed. This holds even if load or increment is asserted across a rising edge.
- R2: When load is asserted at a rising edge, `cnt_o` takes `din_i`, whatever the increment input is doing.
- R3: When increment is asserted and load is not, `cnt_o` rises by one at the edge.
- R4: When neither load nor increment is asserted (and R7 does not apply), `cnt_o` keeps its value.
- R5: Counting up from 15 (1111) gives 0.
- R6: With `CTRL_ACT_LOW`=1, a low level on `ld_i` or `inc_i` asserts that control. With `CTRL_ACT_LOW`=0, a high level asserts it.
- R7: With `DIV12_EN`=1, a count of 11 (1011) without load asserted becomes 0 at the next edge, whatever the increment input is doing.
- R8: With `DIV12_EN`=1, an asserted load at count 11 takes `din_i` instead of the reload to 0.
- R9: With `DIV12_EN`=1, `tc_strobe_o` is 1 exactly while `cnt_o` is 11. With `DIV12_EN`=0, it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active-low |
| inc_i | input | 1 | Increment enable, polarity set by CTRL_ACT_LOW |
| ld_i | input | 1 | Parallel load enable, polarity set by CTRL_ACT_LOW |
| din_i | input | 4 | Parallel load value |
| cnt_o | output | 4 | Current count, bit 0 least significant |
| tc_strobe_o | output | 1 | Terminal-count strobe in divide-by-12 mode |

## Verification
The collision that matters is between an external load and the divide-by-12 reload, which can land on the same edge when the count is 11. The bench steps a divide-by-12 instance up to 11 and asserts load with a non-zero value. It expects that value to appear, not zero, and it also lets random loads fall on that count. A second collision, clear against load or increment, is provoked by holding the clear low across an edge with both controls asserted; the count must stay zero.

// File: rtl/lcnt_pkg.sv
package lcnt_pkg;
   localparam int unsigned CNT_W = 4;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_INC  = 2'd1,
      OP_LOAD = 2'd2,
      OP_ZERO = 2'd3
   } lcnt_op_e;
endpackage

// File: rtl/lcnt_ctrl_decode.sv
module lcnt_ctrl_decode
   import lcnt_pkg::*;
#(
   parameter bit ACT_LOW = 1'b1
) (
   input  logic     inc_raw,
   input  logic     ld_raw,
   input  logic     tc_hit,
   output lcnt_op_e op
);
   logic inc_on;
   logic ld_on;

   generate
      if (ACT_LOW) begin : g_low
         assign inc_on = ~inc_raw;
         assign ld_on  = ~ld_raw;
      end else begin : g_high
         assign inc_on = inc_raw;
         assign ld_on  = ld_raw;
      end
   endgenerate

   // fixed priority: external load, terminal reload, increment, hold
   always_comb begin
      if (ld_on)       op = OP_LOAD;
      else if (tc_hit) op = OP_ZERO;
      else if (inc_on) op = OP_INC;
      else             op = OP_HOLD;
   end
endmodule

// File: rtl/lcnt_core.sv
module lcnt_core
   import lcnt_pkg::*;
#(
   parameter int unsigned W = CNT_W
) (
   input  logic         clk,
   input  logic         clr_n,
   input  lcnt_op_e     op,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         q <= '0;
      end else begin
         unique case (op)
            OP_LOAD: q <= din;
            OP_ZERO: q <= '0;
            OP_INC:  q <= q + ONE;
            default: q <= q;
         endcase
      end
   end
endmodule

// File: rtl/lcnt_tc_tap.sv
module lcnt_tc_tap #(
   parameter int unsigned W      = 4,
   parameter bit          ENABLE = 1'b0,
   parameter int unsigned LAST   = 11
) (
   input  logic [W-1:0] cnt,
   output logic         hit
);
   localparam logic [W-1:0] LAST_V = W'(LAST);

   generate
      if (ENABLE) begin : g_tap
         // one AND gate over per-bit matches (true or inverted taps)
         assign hit = &(cnt ~^ LAST_V);
      end else begin : g_none
         assign hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lcnt_top.sv
module lcnt_top
   import lcnt_pkg::*;
#(
   parameter bit          CTRL_ACT_LOW = 1'b1,
   parameter bit          DIV12_EN     = 1'b0,
   parameter int unsigned WIDTH        = CNT_W
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             inc_i,
   input  logic             ld_i,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             tc_strobe_o
);
   localparam int unsigned DIV_RATIO = 12;
   localparam int unsigned TC_VALUE  = DIV_RATIO - 1;

   generate
      if (WIDTH != CNT_W) begin : g_bad_width
         $error("lcnt_top: WIDTH must be 4");
      end
      if (TC_VALUE >= (1 << WIDTH)) begin : g_bad_tc
         $error("lcnt_top: terminal count does not fit WIDTH");
      end
   endgenerate

   lcnt_op_e op;
   logic     tc_hit;

   lcnt_tc_tap #(
      .W      (WIDTH),
      .ENABLE (DIV12_EN),
      .LAST   (TC_VALUE)
   ) u_tap (
      .cnt (cnt_o),
      .hit (tc_hit)
   );

   lcnt_ctrl_decode #(
      .ACT_LOW (CTRL_ACT_LOW)
   ) u_dec (
      .inc_raw (inc_i),
      .ld_raw  (ld_i),
      .tc_hit  (tc_hit),
      .op      (op)
   );

   lcnt_core #(
      .W (WIDTH)
   ) u_core (
      .clk   (clk),
      .clr_n (clr_n),
      .op    (op),
      .din   (din_i),
      .q     (cnt_o)
   );

   assign tc_strobe_o = tc_hit;
endmodule

// File: rtl/lcnt_top_chk.sv
module lcnt_top_chk #(
   parameter bit          CTRL_ACT_LOW = 1'b1,
   parameter bit          DIV12_EN     = 1'b0,
   parameter int unsigned WIDTH        = 4
) (
   input logic             clk,
   input logic             clr_n,
   input logic             inc_i,
   input logic             ld_i,
   input logic [WIDTH-1:0] din_i,
   input logic [WIDTH-1:0] cnt_o,
   input logic             tc_strobe_o
);
   logic ld_act;
   logic inc_act;
   logic at_tc;

   assign ld_act  = CTRL_ACT_LOW ? !ld_i  : ld_i;
   assign inc_act = CTRL_ACT_LOW ? !inc_i : inc_i;
   assign at_tc   = DIV12_EN && (cnt_o == WIDTH'(11));

   // R1
   clear_zero_chk: assert property (@(posedge clk) !clr_n |-> cnt_o == '0);

   // R2
   load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
      ld_act |=> cnt_o == $past(din_i));

   // R3
   inc_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (inc_act && !ld_act && !at_tc) |=> cnt_o == $past(cnt_o) + WIDTH'(1));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (!inc_act && !ld_act && !at_tc) |=> $stable(cnt_o));

   // R7
   tc_reload_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (at_tc && !ld_act) |=> cnt_o == '0);

   // R9
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!clr_n)
      DIV12_EN || !tc_strobe_o);

   // R9
   strobe_next_chk: assert property (@(posedge clk) disable iff (!clr_n)
      tc_strobe_o |=> (cnt_o == '0) || $past(ld_act));
endmodule

bind lcnt_top lcnt_top_chk #(
   .CTRL_ACT_LOW (CTRL_ACT_LOW),
   .DIV12_EN     (DIV12_EN),
   .WIDTH        (WIDTH)
) u_chk (
   .clk         (clk),
   .clr_n       (clr_n),
   .inc_i       (inc_i),
   .ld_i        (ld_i),
   .din_i       (din_i),
   .cnt_o       (cnt_o),
   .tc_strobe_o (tc_strobe_o)
);

// File: tb/lcnt_top_tb.sv
module lcnt_top_tb;
   logic       clk = 1'b0;
   logic       clr_n = 1'b1;
   logic       a_inc = 1'b1, a_ld = 1'b1;   // active-low instance
   logic       b_inc = 1'b0, b_ld = 1'b0;   // active-high, divide-by-12
   logic [3:0] a_din = 4'd0, b_din = 4'd0;
   logic [3:0] a_cnt, b_cnt;
   logic       a_stb, b_stb;
   logic [3:0] exp_a = 4'd0, exp_b = 4'd0;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   lcnt_top #(.CTRL_ACT_LOW(1'b1), .DIV12_EN(1'b0)) u_dut (
      .clk(clk), .clr_n(clr_n), .inc_i(a_inc), .ld_i(a_ld),
      .din_i(a_din), .cnt_o(a_cnt), .tc_strobe_o(a_stb));

   lcnt_top #(.CTRL_ACT_LOW(1'b0), .DIV12_EN(1'b1)) u_dut_div (
      .clk(clk), .clr_n(clr_n), .inc_i(b_inc), .ld_i(b_ld),
      .din_i(b_din), .cnt_o(b_cnt), .tc_strobe_o(b_stb));

   function automatic logic [3:0] nxt(input logic [3:0] c, input bit ld,
                                      input bit inc, input logic [3:0] d,
                                      input bit div);
      if (ld) return d;
      if (div && c == 4'd11) return 4'd0;
      if (inc) return c + 4'd1;
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic check_all(input string req);
      chk(a_cnt === exp_a, {req, " count A"}, a_cnt, exp_a);
      chk(b_cnt === exp_b, {req, " count B"}, b_cnt, exp_b);
      chk(a_stb === 1'b0, "R9 strobe off when disabled", a_stb, 0);
      chk(b_stb === (exp_b == 4'd11), "R9 strobe at 11", b_stb, exp_b == 4'd11);
   endtask

   // a_* arguments are logical (asserted=1); converted to active-low at pins
   task automatic step(input bit al, input bit ai, input logic [3:0] ad,
                       input bit bl, input bit bi, input logic [3:0] bd,
                       input string req);
      @(negedge clk);
      a_ld = !al; a_inc = !ai; a_din = ad;
      b_ld = bl;  b_inc = bi;  b_din = bd;
      exp_a = nxt(exp_a, al, ai, ad, 1'b0);
      exp_b = nxt(exp_b, bl, bi, bd, 1'b1);
      @(posedge clk);
      #1;
      check_all(req);
   endtask

   initial begin
      #0.5 clr_n = 1'b0;
      #3;
      check_all("R1 reset");
      @(negedge clk);
      clr_n = 1'b1;
      // R2 and R6: load wins over increment, active-low on A, active-high on B
      step(1, 1, 4'd9, 1, 1, 4'd3, "R2 R6 load");
      // R3
      step(0, 1, 4'd0, 0, 1, 4'd0, "R3 increment");
      // R4
      step(0, 0, 4'd5, 0, 0, 4'd5, "R4 hold");
      // R5: wrap 15 -> 0 on A
      step(1, 0, 4'd14, 1, 0, 4'd10, "R2 load");
      step(0, 1, 4'd0, 0, 1, 4'd0, "R5 inc to 15");
      step(0, 1, 4'd0, 0, 0, 4'd0, "R5 wrap R7 tc with inc off");
      // R8: B at 11 with load asserted takes the load value
      step(0, 0, 4'd0, 1, 0, 4'd11, "R2 load 11");
      step(0, 0, 4'd0, 1, 1, 4'd5, "R8 load beats reload");
      // R7: full divide-by-12 cycle
      step(0, 0, 4'd0, 1, 0, 4'd0, "R2 load 0");
      for (int i = 0; i < 12; i++) step(0, 1, 4'd0, 0, 1, 4'd0, "R7 R9 cycle");
      // R1: clear mid-cycle, then across an edge with controls asserted
      @(negedge clk);
      #0.5 clr_n = 1'b0;
      exp_a = 4'd0; exp_b = 4'd0;
      #0.5;
      check_all("R1 async clear");
      a_ld = 1'b0; a_inc = 1'b0; a_din = 4'd7;
      b_ld = 1'b1; b_inc = 1'b1; b_din = 4'd7;
      @(posedge clk);
      #1;
      check_all("R1 clear over load");
      @(negedge clk);
      clr_n = 1'b1;
      a_ld = 1'b1; a_inc = 1'b1; b_ld = 1'b0; b_inc = 1'b0;
      // random phase, R2 R3 R4 R5 R7 R8 R9
      void'($urandom(32'h5A17));
      for (int i = 0; i < 3000; i++) begin
         bit al, ai, bl, bi;
         al = ($urandom % 8) == 0;
         ai = ($urandom % 4) != 0;
         bl = ($urandom % 8) == 0;
         bi = ($urandom % 4) != 0;
         step(al, ai, 4'($urandom), bl, bi, 4'($urandom), "R2-random");
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule